// File: doc/BRIEF.md
# Dual-Source Output Buffer Interrupt Arbiter

This block sits between two byte sources of an input-device controller, a keyboard channel and an auxiliary (pointing device) channel, and the host-facing side of that controller. Each source raises a level while it holds a byte for the host. The arbiter captures both levels into a two-bit pending mask on every clock. From that mask and the controller's mode byte it derives the "output buffer full" flag, the "auxiliary buffer full" flag, one interrupt request per source, and a select that tells the data-port read path which source to pop.

The keyboard channel has priority. The auxiliary flag, the auxiliary interrupt and the auxiliary read select appear only while auxiliary data is the single pending source. The keyboard interrupt is gated both by its enable bit and by the keyboard-disable bit of the mode byte. The flags are presented twice, once for the status byte and once for the output-port byte, so that both registers stay consistent.

Top module: `ob_irq_arbiter`

## Requirements
- R1: While rst_ni is low, the pending mask is clear and every output is 0, whatever the source levels; an asynchronous reset clears the outputs without waiting for a clock edge.
- R2: Pending bit 0 (keyboard) and bit 1 (auxiliary) take the values of kbd_avail_i and aux_avail_i at each rising clock edge, so a level change reaches the outputs one clock later.
- R3: stat_obf_o and oport_obf_o are 1 exactly when at least one pending bit is set.
- R4: stat_aux_obf_o and oport_aux_obf_o are 1 exactly when the pending mask is 2'b10 (auxiliary only).
- R5: aux_irq_o is 1 exactly when the pending mask is 2'b10 and mode_i[1] is 1.
- R6: kbd_irq_o is 1 exactly when pending bit 0 is set, mode_i[0] is 1 and mode_i[4] is 0.
- R7: With both sources pending, the auxiliary flags, aux_irq_o and rd_sel_aux_o are 0; the keyboard is served.
- R8: rd_sel_aux_o is 1 (read from auxiliary) exactly when the pending mask is 2'b10, and 0 (read from keyboard) otherwise.
- R9: A change of mode_i takes effect on the interrupt outputs in the same cycle, without a clock edge.
- R10: mode_i bits 2, 3, 5, 6 and 7 have no effect on any output, and neither interrupt is raised while nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kbd_avail_i | input | 1 | Keyboard source holds a byte |
| aux_avail_i | input | 1 | Auxiliary source holds a byte |
| mode_i | input | 8 | Controller mode byte (bit 0 keyboard interrupt enable, bit 1 auxiliary interrupt enable, bit 4 keyboard disable) |
| stat_obf_o | output | 1 | Status byte: some byte is waiting |
| stat_aux_obf_o | output | 1 | Status byte: waiting byte is from the auxiliary source |
| oport_obf_o | output | 1 | Output-port byte: some byte is waiting |
| oport_aux_obf_o | output | 1 | Output-port byte: waiting byte is from the auxiliary source |
| kbd_irq_o | output | 1 | Keyboard interrupt request level |
| aux_irq_o | output | 1 | Auxiliary interrupt request level |
| rd_sel_aux_o | output | 1 | Data-port read select, 1 = auxiliary source |

## Verification
A change on either source level is registered once, so its effect on every output is due one rising edge later; the bench drives levels on a falling edge and checks them on the following falling edge, and also looks just after the drive to confirm nothing moved early. Mode changes reach the outputs without a register, so the directed mode test samples a nanosecond after driving, before any edge. Reset is checked both while held and when asserted mid-cycle, where the outputs must drop at once.

// File: rtl/ob_arb_pkg.sv
package ob_arb_pkg;
  localparam int unsigned NSRC       = 2;
  localparam int unsigned SRC_KBD    = 0;
  localparam int unsigned SRC_AUX    = 1;
  localparam int unsigned MODE_W     = 8;
  localparam int unsigned MB_KBD_IE  = 0;
  localparam int unsigned MB_AUX_IE  = 1;
  localparam int unsigned MB_KBD_DIS = 4;

  typedef logic [NSRC-1:0] pend_t;

  typedef struct packed {
    logic any;
    logic aux_only;
  } ob_flags_t;
endpackage

// File: rtl/ob_pending_reg.sv
module ob_pending_reg #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[g] <= 1'b0;
      else         pend_o[g] <= lvl_i[g];
    end
  end
endmodule

// File: rtl/ob_flag_decode.sv
module ob_flag_decode
  import ob_arb_pkg::*;
(
  input  pend_t     pend_i,
  output ob_flags_t flags_o,
  output logic      sel_aux_o
);
  pend_t aux_alone;

  always_comb begin
    aux_alone          = '0;
    aux_alone[SRC_AUX] = 1'b1;
    flags_o.any        = |pend_i;
    // keyboard has priority: aux flagged only when it is the sole source
    flags_o.aux_only   = (pend_i == aux_alone);
    sel_aux_o          = flags_o.aux_only;
  end
endmodule

// File: rtl/ob_irq_gate.sv
module ob_irq_gate
  import ob_arb_pkg::*;
(
  input  logic              kbd_pend_i,
  input  logic              aux_only_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              kbd_irq_o,
  output logic              aux_irq_o
);
  always_comb begin
    kbd_irq_o = kbd_pend_i & mode_i[MB_KBD_IE] & ~mode_i[MB_KBD_DIS];
    aux_irq_o = aux_only_i & mode_i[MB_AUX_IE];
  end
endmodule

// File: rtl/ob_irq_arbiter.sv
module ob_irq_arbiter
  import ob_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kbd_avail_i,
  input  logic              aux_avail_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              stat_obf_o,
  output logic              stat_aux_obf_o,
  output logic              oport_obf_o,
  output logic              oport_aux_obf_o,
  output logic              kbd_irq_o,
  output logic              aux_irq_o,
  output logic              rd_sel_aux_o
);
  pend_t     lvl;
  pend_t     pend;
  ob_flags_t flags;

  always_comb begin
    lvl          = '0;
    lvl[SRC_KBD] = kbd_avail_i;
    lvl[SRC_AUX] = aux_avail_i;
  end

  ob_pending_reg #(.N(NSRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .pend_o (pend)
  );

  ob_flag_decode u_dec (
    .pend_i    (pend),
    .flags_o   (flags),
    .sel_aux_o (rd_sel_aux_o)
  );

  ob_irq_gate u_irq (
    .kbd_pend_i (pend[SRC_KBD]),
    .aux_only_i (flags.aux_only),
    .mode_i     (mode_i),
    .kbd_irq_o  (kbd_irq_o),
    .aux_irq_o  (aux_irq_o)
  );

  assign stat_obf_o      = flags.any;
  assign oport_obf_o     = flags.any;
  assign stat_aux_obf_o  = flags.aux_only;
  assign oport_aux_obf_o = flags.aux_only;
endmodule

// File: rtl/ob_irq_arbiter_chk.sv
module ob_irq_arbiter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       kbd_avail_i,
  input logic       aux_avail_i,
  input logic [7:0] mode_i,
  input logic       stat_obf_o,
  input logic       stat_aux_obf_o,
  input logic       oport_obf_o,
  input logic       oport_aux_obf_o,
  input logic       kbd_irq_o,
  input logic       aux_irq_o,
  input logic       rd_sel_aux_o
);
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> !(stat_obf_o || kbd_irq_o || aux_irq_o || rd_sel_aux_o));

  p_follow_kbd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(kbd_avail_i)) |-> stat_obf_o);

  p_flag_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oport_obf_o == stat_obf_o) && (oport_aux_obf_o == stat_aux_obf_o));

  p_aux_alone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_aux_obf_o |-> ($past(aux_avail_i) && !$past(kbd_avail_i)));

  p_aux_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_irq_o |-> (mode_i[1] && stat_aux_obf_o));

  p_kbd_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kbd_irq_o |-> (mode_i[0] && !mode_i[4] && stat_obf_o && !stat_aux_obf_o));

  p_one_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({kbd_irq_o, aux_irq_o}));

  p_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_aux_o |-> (stat_obf_o && !kbd_irq_o));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_obf_o |-> !(kbd_irq_o || aux_irq_o || rd_sel_aux_o));
endmodule

bind ob_irq_arbiter ob_irq_arbiter_chk u_chk (.*);

// File: tb/ob_irq_arbiter_test.sv
module ob_irq_arbiter_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       kbd_avail_i = 1'b0;
  logic       aux_avail_i = 1'b0;
  logic [7:0] mode_i = 8'h03;
  logic       stat_obf_o, stat_aux_obf_o, oport_obf_o, oport_aux_obf_o;
  logic       kbd_irq_o, aux_irq_o, rd_sel_aux_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  ob_irq_arbiter uut (.*);

  // {stat_obf, stat_aux, oport_obf, oport_aux, kbd_irq, aux_irq, sel_aux}
  function automatic logic [6:0] outs();
    return {stat_obf_o, stat_aux_obf_o, oport_obf_o, oport_aux_obf_o,
            kbd_irq_o, aux_irq_o, rd_sel_aux_o};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // {kbd, aux, mode[7:0], expected[6:0]}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h03, 7'b0000000},
    {1'b1, 1'b0, 8'h03, 7'b1010100},
    {1'b0, 1'b1, 8'h03, 7'b1111011},
    {1'b1, 1'b1, 8'h03, 7'b1010100},
    {1'b1, 1'b0, 8'h13, 7'b1010000},
    {1'b0, 1'b1, 8'h13, 7'b1111011},
    {1'b1, 1'b0, 8'h02, 7'b1010000},
    {1'b0, 1'b1, 8'h01, 7'b1111001},
    {1'b1, 1'b1, 8'h02, 7'b1010000},
    {1'b0, 1'b1, 8'hEC, 7'b1111001},
    {1'b1, 1'b0, 8'hEF, 7'b1010100},
    {1'b0, 1'b0, 8'hFF, 7'b0000000},
    {1'b1, 1'b1, 8'hFC, 7'b1010000}
  };

  initial begin
    #(8 * 2000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: levels high while reset held
    kbd_avail_i = 1'b1;
    aux_avail_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 held reset", outs(), 7'b0000000);
    kbd_avail_i = 1'b0;
    aux_avail_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release idle", outs(), 7'b0000000);

    // vector walk: R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      kbd_avail_i = VEC[i][16];
      aux_avail_i = VEC[i][15];
      mode_i      = VEC[i][14:7];
      @(posedge clk_i);
      @(negedge clk_i);
      check($sformatf("R3 R4 R5 R6 R7 R8 R10 vector %0d", i), outs(), VEC[i][6:0]);
    end

    // R2: one clock latency from level to outputs
    kbd_avail_i = 1'b0;
    aux_avail_i = 1'b0;
    mode_i = 8'h03;
    @(negedge clk_i);
    @(negedge clk_i);
    aux_avail_i = 1'b1;
    #1;
    check("R2 no early aux", outs(), 7'b0000000);
    @(posedge clk_i);
    #1;
    check("R2 aux after edge", outs(), 7'b1111011);
    @(negedge clk_i);
    kbd_avail_i = 1'b1;
    #1;
    check("R2 aux held before kbd edge", outs(), 7'b1111011);
    @(posedge clk_i);
    #1;
    check("R7 kbd wins after edge", outs(), 7'b1010100);

    // R9: mode acts without an edge
    @(negedge clk_i);
    kbd_avail_i = 1'b1;
    aux_avail_i = 1'b0;
    @(negedge clk_i);
    mode_i = 8'h13;
    #1;
    check("R9 kbd disable immediate", outs(), 7'b1010000);
    mode_i = 8'h03;
    #1;
    check("R9 kbd enable immediate", outs(), 7'b1010100);
    @(negedge clk_i);
    kbd_avail_i = 1'b0;
    aux_avail_i = 1'b1;
    @(negedge clk_i);
    mode_i = 8'h01;
    #1;
    check("R9 aux mask immediate", outs(), 7'b1111001);

    // R10: irrelevant mode bits toggled with aux pending
    mode_i = 8'hFE;
    #1;
    check("R10 upper bits no effect", outs(), 7'b1111011);

    // R1: asynchronous reset mid-cycle
    @(negedge clk_i);
    #2;
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", outs(), 7'b0000000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    aux_avail_i = 1'b0;
    @(negedge clk_i);
    check("R1 idle after reassert", outs(), 7'b0000000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule